// File: doc/BRIEF.md
# Protection Key Checking Unit

This block keeps a small register cache of protection keys that software fills and replaces. Each entry holds a key, a valid flag and three deny flags: one for data reads, one for data writes and one for instruction fetches. Software loads any entry through an index, a 64-bit word and a write strobe, and can read any entry back through a separate read index. The hardware never picks a victim or replaces an entry on its own.

On the lookup side, a translation presents its key and an access type with a valid strobe. The key is compared in parallel against every valid entry. The outcome is one of three results. A key miss means no valid entry holds that key. A key permission fault means an entry matched but its deny flag for this access type is set. Otherwise the access is permitted. The outcome is registered and appears on the cycle after the strobe, together with the index of the entry that decided it.

Top module: `pkey_check_unit`

## Requirements
- R1: Reset clears every entry, so read-back returns zero, all result outputs are low, and every lookup after reset reports a key miss until software loads keys.
- R2: When `wr_en` is high at a clock edge, entry `wr_idx` takes `wr_data`. Bit 0 is valid, bit 1 denies writes, bit 2 denies reads, bit 3 denies fetches, and bits 31:8 hold the key. `rd_data` returns entry `rd_idx` in the same layout, with bits 7:4 and 63:32 always zero.
- R3: `res_valid` is high in the cycle after a cycle with `lk_valid` high and low otherwise. While it is low, `res_ok`, `res_key_miss`, `res_key_perm` and `res_idx` are all zero.
- R4: While `res_valid` is high, exactly one of `res_ok`, `res_key_miss` and `res_key_perm` is high.
- R5: A lookup whose key matches no entry with bit 0 set reports `res_key_miss` with `res_idx` zero. Entries with bit 0 clear are ignored even when their key field equals the lookup key.
- R6: When an entry matches, `res_key_perm` is raised if the entry's deny flag for the access type is set. Access codes on `lk_acc` are 0 read (checks bit 2), 1 write (checks bit 1) and 2 fetch (checks bit 3). Code 3 is never permitted and always reports `res_key_perm` on a match.
- R7: When an entry matches and its relevant deny flag is clear, `res_ok` is raised, and `res_idx` gives that entry's index for both ok and permission results.
- R8: When several valid entries hold the lookup key, the lowest-indexed one decides both the result and `res_idx`.
- R9: A write in the same cycle as a lookup does not affect that lookup. It affects only lookups issued in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry to write |
| wr_data | input | 64 | Entry word to store |
| rd_idx | input | 4 | Entry to read back |
| rd_data | output | 64 | Read-back word of entry `rd_idx` |
| lk_valid | input | 1 | Lookup strobe |
| lk_key | input | 24 | Key of the translation |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 never allowed |
| res_valid | output | 1 | Result present, one cycle after `lk_valid` |
| res_ok | output | 1 | Access permitted |
| res_key_miss | output | 1 | No valid entry holds the key |
| res_key_perm | output | 1 | Matching entry denies this access type |
| res_idx | output | 4 | Index of the deciding entry, zero on miss |

## Verification
The hardest case to reach is a lookup that lands in the same cycle as a write that changes its outcome. Examples are a write that installs the key being looked up, or one that invalidates the lowest duplicate. A random stimulus only rarely lines these up. The bench therefore drives them deliberately: a lookup together with a write of its own key must miss, and the next lookup must hit. Duplicate keys with different deny flags are placed at a low and a high index, and the low one is then invalidated. A random phase over a handful of keys then mixes writes and lookups, with the reference model checking every cycle.

// File: rtl/pkey_pkg.sv
package pkey_pkg;

    localparam int PK_ENTRIES = 16;
    localparam int PK_KEY_W   = 24;
    localparam int PK_WORD_W  = 64;

    // Field positions inside the software-visible entry word.
    localparam int POS_VLD    = 0;
    localparam int POS_WDENY  = 1;
    localparam int POS_RDENY  = 2;
    localparam int POS_XDENY  = 3;
    localparam int POS_KEY_LO = 8;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_BAD   = 2'd3
    } acc_e;

endpackage

// File: rtl/pkey_entry_file.sv
module pkey_entry_file
    import pkey_pkg::*;
#(
    parameter int N_ENT = PK_ENTRIES,
    parameter int KEY_W = PK_KEY_W,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [PK_WORD_W-1:0]     wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [PK_WORD_W-1:0]     rd_data,
    output logic [N_ENT-1:0]         ent_vld,
    output logic [N_ENT-1:0]         ent_wdeny,
    output logic [N_ENT-1:0]         ent_rdeny,
    output logic [N_ENT-1:0]         ent_xdeny,
    output logic [N_ENT-1:0][KEY_W-1:0] ent_key
);

    typedef struct packed {
        logic [N_ENT-1:0]            vld;
        logic [N_ENT-1:0]            wdeny;
        logic [N_ENT-1:0]            rdeny;
        logic [N_ENT-1:0]            xdeny;
        logic [N_ENT-1:0][KEY_W-1:0] key;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    // Reserved bits are not stored; they are simply dropped here.
    logic unused_rsvd;
    assign unused_rsvd = ^{wr_data[PK_WORD_W-1:POS_KEY_LO+KEY_W],
                           wr_data[POS_KEY_LO-1:POS_XDENY+1]};

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (int'(wr_idx) < N_ENT)) begin
            tbl_d.vld[wr_idx]   = wr_data[POS_VLD];
            tbl_d.wdeny[wr_idx] = wr_data[POS_WDENY];
            tbl_d.rdeny[wr_idx] = wr_data[POS_RDENY];
            tbl_d.xdeny[wr_idx] = wr_data[POS_XDENY];
            tbl_d.key[wr_idx]   = wr_data[POS_KEY_LO +: KEY_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < N_ENT) begin
            rd_data[POS_VLD]             = tbl_q.vld[rd_idx];
            rd_data[POS_WDENY]           = tbl_q.wdeny[rd_idx];
            rd_data[POS_RDENY]           = tbl_q.rdeny[rd_idx];
            rd_data[POS_XDENY]           = tbl_q.xdeny[rd_idx];
            rd_data[POS_KEY_LO +: KEY_W] = tbl_q.key[rd_idx];
        end
    end

    assign ent_vld   = tbl_q.vld;
    assign ent_wdeny = tbl_q.wdeny;
    assign ent_rdeny = tbl_q.rdeny;
    assign ent_xdeny = tbl_q.xdeny;
    assign ent_key   = tbl_q.key;

endmodule

// File: rtl/pkey_match.sv
module pkey_match #(
    parameter int N_ENT = 16,
    parameter int KEY_W = 24,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0]            ent_vld,
    input  logic [N_ENT-1:0][KEY_W-1:0] ent_key,
    input  logic [KEY_W-1:0]            lk_key,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx
);

    logic [N_ENT-1:0] eq_vec;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign eq_vec[g] = ent_vld[g] && (ent_key[g] == lk_key);
    end

    // Lowest index wins: scan downward so the last assignment is the lowest.
    always_comb begin
        hit_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (eq_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit = |eq_vec;

endmodule

// File: rtl/pkey_perm.sv
module pkey_perm
    import pkey_pkg::*;
(
    input  logic       wdeny,
    input  logic       rdeny,
    input  logic       xdeny,
    input  logic [1:0] acc,
    output logic       deny
);

    always_comb begin
        unique case (acc_e'(acc))
            ACC_READ:  deny = rdeny;
            ACC_WRITE: deny = wdeny;
            ACC_FETCH: deny = xdeny;
            default:   deny = 1'b1;
        endcase
    end

endmodule

// File: rtl/pkey_check_unit.sv
module pkey_check_unit
    import pkey_pkg::*;
#(
    parameter int N_ENT = PK_ENTRIES,
    parameter int KEY_W = PK_KEY_W,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [PK_WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [PK_WORD_W-1:0] rd_data,
    input  logic                 lk_valid,
    input  logic [KEY_W-1:0]     lk_key,
    input  logic [1:0]           lk_acc,
    output logic                 res_valid,
    output logic                 res_ok,
    output logic                 res_key_miss,
    output logic                 res_key_perm,
    output logic [IDX_W-1:0]     res_idx
);

    typedef struct packed {
        logic             valid;
        logic             ok;
        logic             miss;
        logic             perm;
        logic [IDX_W-1:0] idx;
    } res_t;

    res_t res_d, res_q;

    logic [N_ENT-1:0]            ent_vld;
    logic [N_ENT-1:0]            ent_wdeny;
    logic [N_ENT-1:0]            ent_rdeny;
    logic [N_ENT-1:0]            ent_xdeny;
    logic [N_ENT-1:0][KEY_W-1:0] ent_key;
    logic                        hit;
    logic [IDX_W-1:0]            hit_idx;
    logic                        deny;

    pkey_entry_file #(.N_ENT(N_ENT), .KEY_W(KEY_W)) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .ent_vld   (ent_vld),
        .ent_wdeny (ent_wdeny),
        .ent_rdeny (ent_rdeny),
        .ent_xdeny (ent_xdeny),
        .ent_key   (ent_key)
    );

    pkey_match #(.N_ENT(N_ENT), .KEY_W(KEY_W)) u_match (
        .ent_vld (ent_vld),
        .ent_key (ent_key),
        .lk_key  (lk_key),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    pkey_perm u_perm (
        .wdeny (ent_wdeny[hit_idx]),
        .rdeny (ent_rdeny[hit_idx]),
        .xdeny (ent_xdeny[hit_idx]),
        .acc   (lk_acc),
        .deny  (deny)
    );

    always_comb begin
        res_d = '0;
        if (lk_valid) begin
            res_d.valid = 1'b1;
            if (!hit) begin
                res_d.miss = 1'b1;
            end else begin
                res_d.idx  = hit_idx;
                res_d.perm = deny;
                res_d.ok   = !deny;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid    = res_q.valid;
    assign res_ok       = res_q.ok;
    assign res_key_miss = res_q.miss;
    assign res_key_perm = res_q.perm;
    assign res_idx      = res_q.idx;

endmodule

// File: rtl/pkey_check_sva.sv
module pkey_check_sva
    import pkey_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lk_valid,
    input logic [PK_WORD_W-1:0] rd_data,
    input logic                 res_valid,
    input logic                 res_ok,
    input logic                 res_key_miss,
    input logic                 res_key_perm,
    input logic [IDX_W-1:0]     res_idx
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_ok, res_key_miss, res_key_perm}) == 1)); // R4

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_ok && !res_key_miss && !res_key_perm && res_idx == '0)); // R3

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R3

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid); // R3

    AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_key_miss |-> (res_idx == '0)); // R5

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[PK_WORD_W-1:32] == '0) && (rd_data[POS_KEY_LO-1:POS_XDENY+1] == '0)); // R2

endmodule

bind pkey_check_unit pkey_check_sva #(.IDX_W(IDX_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .rd_data      (rd_data),
    .res_valid    (res_valid),
    .res_ok       (res_ok),
    .res_key_miss (res_key_miss),
    .res_key_perm (res_key_perm),
    .res_idx      (res_idx)
);

// File: tb/pkey_check_unit_tb.sv
`timescale 1ns/1ps
module pkey_check_unit_tb;

    localparam logic [63:0] KEEP = 64'h0000_0000_FFFF_FF0F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [63:0] wr_data;
    logic [3:0]  rd_idx;
    logic [63:0] rd_data;
    logic        lk_valid;
    logic [23:0] lk_key;
    logic [1:0]  lk_acc;
    logic        res_valid, res_ok, res_key_miss, res_key_perm;
    logic [3:0]  res_idx;

    int checks = 0;
    int failures = 0;
    logic [63:0] mdl [16];

    always #5 clk = ~clk;

    pkey_check_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .lk_valid(lk_valid), .lk_key(lk_key),
        .lk_acc(lk_acc), .res_valid(res_valid), .res_ok(res_ok),
        .res_key_miss(res_key_miss), .res_key_perm(res_key_perm), .res_idx(res_idx)
    );

    function automatic logic [63:0] ent(bit v, bit wd, bit rd, bit xd, logic [23:0] k);
        ent = {32'h0, k, 4'h0, xd, rd, wd, v};
    endfunction

    // Result packed as {valid, ok, miss, perm, idx}.
    function automatic logic [7:0] ref_lookup(logic [23:0] k, logic [1:0] a);
        for (int i = 0; i < 16; i++) begin
            if (mdl[i][0] && mdl[i][31:8] == k) begin
                bit d;
                case (a)
                    2'd0: d = mdl[i][2];
                    2'd1: d = mdl[i][1];
                    2'd2: d = mdl[i][3];
                    default: d = 1'b1;
                endcase
                return {1'b1, !d, 1'b0, d, 4'(i)};
            end
        end
        return 8'b1010_0000;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(string req, bit we, int widx, logic [63:0] wd,
                       bit lv, logic [23:0] k, logic [1:0] a, int ridx);
        logic [7:0] exp_res;
        logic [7:0] act_res;
        wr_en = we; wr_idx = 4'(widx); wr_data = wd;
        lk_valid = lv; lk_key = k; lk_acc = a; rd_idx = 4'(ridx);
        exp_res = lv ? ref_lookup(k, a) : 8'h00;
        @(posedge clk);
        if (we) mdl[widx] = wd & KEEP;
        @(negedge clk);
        act_res = {res_valid, res_ok, res_key_miss, res_key_perm, res_idx};
        chk(act_res === exp_res, req, 64'(act_res), 64'(exp_res));
        chk(rd_data === mdl[ridx], "R2 readback", rd_data, mdl[ridx]);
    endtask

    task automatic idle(string req);
        cyc(req, 0, 0, 64'h0, 0, 24'h0, 2'd0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        rst_n = 0; wr_en = 0; wr_idx = 0; wr_data = 0; rd_idx = 0;
        lk_valid = 0; lk_key = 0; lk_acc = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({res_valid, res_ok, res_key_miss, res_key_perm, res_idx} === 8'h0,
            "R1 reset outputs", 64'({res_valid, res_ok, res_key_miss, res_key_perm, res_idx}), 64'h0);
        chk(rd_data === 64'h0, "R1 reset readback", rd_data, 64'h0);
        rst_n = 1;
        cyc("R1 miss after reset", 0, 0, 64'h0, 1, 24'h000000, 2'd0, 0);
        cyc("R1 miss after reset", 0, 0, 64'h0, 1, 24'hABCDEF, 2'd1, 5);

        // R2: load with reserved bits set, check they read back zero
        cyc("R2 write", 1, 3, 64'hFFFF_FFFF_ABCD_EFF1, 0, 24'h0, 2'd0, 3);
        cyc("R2 write", 1, 5, 64'h5A5A_0000_1234_56F3, 0, 24'h0, 2'd0, 5);
        cyc("R2 write", 1, 7, ent(1, 0, 1, 0, 24'h000777), 0, 24'h0, 2'd0, 7);
        cyc("R2 write", 1, 9, ent(1, 0, 0, 1, 24'h000999), 0, 24'h0, 2'd0, 9);
        cyc("R2 write", 1, 10, ent(0, 0, 0, 0, 24'h55AA55), 0, 24'h0, 2'd0, 10);
        idle("R3 idle");

        // R7: permitted accesses
        cyc("R7 read ok", 0, 0, 64'h0, 1, 24'hABCDEF, 2'd0, 3);
        cyc("R7 write ok", 0, 0, 64'h0, 1, 24'hABCDEF, 2'd1, 3);
        cyc("R7 fetch ok", 0, 0, 64'h0, 1, 24'hABCDEF, 2'd2, 3);
        cyc("R7 read ok", 0, 0, 64'h0, 1, 24'h123456, 2'd0, 5);
        // R6: deny flags per access type
        cyc("R6 write deny", 0, 0, 64'h0, 1, 24'h123456, 2'd1, 5);
        cyc("R6 read deny", 0, 0, 64'h0, 1, 24'h000777, 2'd0, 7);
        cyc("R6 fetch deny", 0, 0, 64'h0, 1, 24'h000999, 2'd2, 9);
        cyc("R7 fetch ok rd-deny entry", 0, 0, 64'h0, 1, 24'h000777, 2'd2, 7);
        cyc("R6 code 3", 0, 0, 64'h0, 1, 24'hABCDEF, 2'd3, 3);
        // R5: invalid entry ignored
        cyc("R5 invalid ignored", 0, 0, 64'h0, 1, 24'h55AA55, 2'd0, 10);
        cyc("R5 unknown key", 0, 0, 64'h0, 1, 24'h0000AB, 2'd1, 0);
        // R3: matching key without strobe produces nothing
        cyc("R3 no strobe", 0, 0, 64'h0, 0, 24'hABCDEF, 2'd0, 3);

        // R8: duplicates, lowest index decides
        cyc("R8 setup", 1, 12, ent(1, 0, 0, 1, 24'h0BEEF0), 0, 24'h0, 2'd0, 12);
        cyc("R8 setup", 1, 2, ent(1, 0, 0, 0, 24'h0BEEF0), 0, 24'h0, 2'd0, 2);
        cyc("R8 lowest wins", 0, 0, 64'h0, 1, 24'h0BEEF0, 2'd2, 2);
        cyc("R8 invalidate low", 1, 2, 64'h0, 0, 24'h0, 2'd0, 2);
        cyc("R8 next match", 0, 0, 64'h0, 1, 24'h0BEEF0, 2'd2, 12);

        // R9: same-cycle write is not seen by the lookup
        cyc("R9 same-cycle install", 1, 0, ent(1, 0, 0, 0, 24'h999999), 1, 24'h999999, 2'd0, 0);
        cyc("R9 after install", 0, 0, 64'h0, 1, 24'h999999, 2'd0, 0);
        cyc("R9 same-cycle deny", 1, 0, ent(1, 0, 1, 0, 24'h999999), 1, 24'h999999, 2'd0, 0);
        cyc("R9 after deny", 0, 0, 64'h0, 1, 24'h999999, 2'd0, 0);
        cyc("R9 same-cycle drop", 1, 0, 64'h0, 1, 24'h999999, 2'd0, 0);
        cyc("R9 after drop", 0, 0, 64'h0, 1, 24'h999999, 2'd0, 0);

        // R4: random mix over a small key set
        for (int n = 0; n < 400; n++) begin
            logic [63:0] w;
            w = {$urandom, $urandom};
            w[31:8] = 24'h000100 + 24'($urandom % 6);
            cyc("R4 random", ($urandom % 3) == 0, int'($urandom % 16), w,
                ($urandom % 4) != 0, 24'h000100 + 24'($urandom % 7),
                2'($urandom), int'($urandom % 16));
        end

        // R1: reset clears loaded entries
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        cyc("R1 reset clears", 0, 0, 64'h0, 1, 24'hABCDEF, 2'd0, 3);
        cyc("R1 reset clears", 0, 0, 64'h0, 1, 24'h000100, 2'd0, 9);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule